// File: doc/BRIEF.md
# I2C Bus Timing Divider Search

This block turns a clock ratio (input clock frequency over target I2C bus frequency, divided beforehand) and a 3-bit glitch-filter cycle count into the divider and phase timing settings of an I2C master. After a start pulse it takes a base count, which is the ratio less eight less twice the filter count. It then checks one divider candidate per clock for a quotient inside an accepted window. When a candidate is accepted, a serial divider produces the exact quotient. From that quotient the block derives every SCL phase length and every setup and hold length, and it packs them into four 32-bit timing words.

The controller is a Moore state machine with six states. `ST_IDLE` is the state after reset. `ST_SCAN` checks one candidate per cycle. `ST_DIVIDE` runs the bit-serial quotient. `ST_PACK` registers the timing words. `ST_DONE` and `ST_FAIL` hold the result. The transitions are:

- IDLE→SCAN on start.
- SCAN→DIVIDE when the current candidate fits the window.
- SCAN→FAIL when the last candidate does not fit.
- SCAN→SCAN otherwise.
- DIVIDE→PACK when the quotient is ready.
- PACK→DONE unconditionally.
- DONE→SCAN and FAIL→SCAN on a new start.

A start that arrives while the block is busy is ignored.

Top module: `i2c_tdiv_search`

## Requirements
- R1: After reset, busy, done and err are low, and clk_div, clk_cycle and all four timing words are zero.
- R2: The base count is ratio − 8 − 2·filt_cyc, where filt_cyc is 3 bits wide. If ratio < 8 + 2·filt_cyc, the base is taken as zero, so no candidate fits and the search ends in error.
- R3: The result is the smallest index i in 0..255 whose quotient q = floor(base/(i+1)) satisfies 4 < q < 512. The block then raises done, sets clk_div = i and sets clk_cycle = q − 2.
- R4: If no index in 0..255 fits the window, err is raised, and clk_div, clk_cycle and all four timing words read zero.
- R5: With L = floor(clk_cycle/2), SCL low is L in tw_bit[15:8] and SCL high is L in tw_bit[7:0]. START setup is L in tw_edges[31:24], START hold is L in tw_edges[23:16] and STOP setup is L in tw_edges[15:8]. tw_edges[7:0] is zero.
- R6: Data setup is floor(L/2) in tw_bit[31:24], and tw_bit[23:16] is zero. Data hold is floor(L/2) in tw_hold[7:0], and the rest of tw_hold is zero.
- R7: tw_rate carries clk_div in bits 23:16 and clk_cycle, the stretch-release time, zero-extended in bits 15:0. Bits 31:24 are zero.
- R8: A start pulse while the block is not busy begins a search. In the next cycle busy is high and done and err are low. ratio and filt_cyc are sampled only at that start, so later changes to them have no effect.
- R9: A start pulse while busy is ignored, and the result is that of the search already running.
- R10: Exactly one candidate is checked per clock. Done or err follows a start within 256 + RATIO_W + 4 cycles.
- R11: done or err, and all result outputs, hold unchanged until the next start. At most one of busy, done and err is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle pulse that begins a search |
| ratio | input | RATIO_W | Input clock over bus clock ratio |
| filt_cyc | input | FILT_W | Glitch-filter cycle count |
| busy | output | 1 | Search, divide or pack in progress |
| done | output | 1 | A valid divider was found |
| err | output | 1 | No candidate fits the window |
| clk_div | output | IDX_W | Accepted divider index |
| clk_cycle | output | CYC_W | Quotient minus two |
| tw_edges | output | 32 | START setup, START hold and STOP setup fields |
| tw_bit | output | 32 | Data setup, SCL low and SCL high fields |
| tw_rate | output | 32 | Divider and release time fields |
| tw_hold | output | 32 | Data hold field |

## Verification
Suppose the scan index or the window bound runs out of step. The port then shows a clk_div one off from the bench model, or an err where done was expected. This appears as soon as done or err rises, no later than about 290 cycles after start. A fault in the serial divider shows only in clk_cycle and in the words derived from it, at the same moment. A fault in the state machine shows as busy overlapping done, as a start accepted mid-search, or as a result that drifts while it should be held. The checker reports each of these within one cycle.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int FLD_W  = 8;
    localparam int WORD_W = 32;
    localparam int REL_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DIVIDE,
        ST_PACK,
        ST_DONE,
        ST_FAIL
    } srch_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] edges;
        logic [WORD_W-1:0] bitw;
        logic [WORD_W-1:0] rate;
        logic [WORD_W-1:0] hold;
    } timing_words_t;

endpackage

// File: rtl/i2ct_scan.sv
// Candidate walker: tests base against the window 5*(i+1) <= base < 512*(i+1),
// which is the multiply-free form of 4 < base/(i+1) < 512.
module i2ct_scan #(
    parameter int RATIO_W = 32,
    parameter int STEPS   = 256,
    parameter int Q_MIN   = 5,
    parameter int Q_MAX   = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       step,
    input  logic [RATIO_W-1:0]         base,
    output logic [$clog2(STEPS)-1:0]   idx,
    output logic                       hit,
    output logic                       last
);
    localparam int IDX_W = $clog2(STEPS);
    localparam int LO_W  = $clog2(Q_MIN * STEPS + 1);
    localparam int HI_W  = $clog2(Q_MAX * STEPS + 1);
    localparam int CMP_W = (RATIO_W > HI_W) ? RATIO_W : HI_W;

    logic [IDX_W-1:0] idx_q;
    logic [LO_W-1:0]  lo_q;
    logic [CMP_W-1:0] base_c;
    logic [CMP_W-1:0] lo_c;
    logic [CMP_W-1:0] hi_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            lo_q  <= LO_W'(Q_MIN);
        end else if (clear) begin
            idx_q <= '0;
            lo_q  <= LO_W'(Q_MIN);
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
            lo_q  <= lo_q + LO_W'(Q_MIN);
        end
    end

    always_comb begin
        base_c = CMP_W'(base);
        lo_c   = CMP_W'(lo_q);
        hi_c   = (CMP_W'(idx_q) + CMP_W'(1)) * CMP_W'(Q_MAX);
    end

    assign idx  = idx_q;
    assign hit  = (base_c >= lo_c) && (base_c < hi_c);
    assign last = (idx_q == IDX_W'(STEPS - 1));

endmodule

// File: rtl/i2ct_sdiv.sv
// Restoring bit-serial divider, one quotient bit per clock.
module i2ct_sdiv #(
    parameter int DVD_W = 32,
    parameter int DVS_W = 9,
    parameter int QO_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             ready,
    output logic [QO_W-1:0]  quotient
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dvs_q;
    logic [DVD_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;
    logic             ge;

    always_comb begin
        trial = {rem_q, quo_q[DVD_W-1]};
        diff  = trial - {1'b0, dvs_q};
        ge    = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            dvs_q <= divisor;
            quo_q <= dividend;
            cnt_q <= CNT_W'(DVD_W);
        end else if (cnt_q != '0) begin
            rem_q <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            quo_q <= {quo_q[DVD_W-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign ready    = (cnt_q == '0);
    assign quotient = quo_q[QO_W-1:0];

endmodule

// File: rtl/i2ct_pack.sv
// Derives every phase field from the accepted cycle count and places it.
module i2ct_pack
    import i2ct_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CYC_W = 9
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic [IDX_W-1:0] div,
    output timing_words_t    words
);
    logic [FLD_W-1:0] half_f;
    logic [FLD_W-1:0] quart_f;
    logic [FLD_W-1:0] div_f;
    logic [REL_W-1:0] rel_f;

    always_comb begin
        half_f  = FLD_W'(cyc >> 1);
        quart_f = half_f >> 1;
        div_f   = FLD_W'(div);
        rel_f   = REL_W'(cyc);

        words.edges = {half_f, half_f, half_f, {FLD_W{1'b0}}};
        words.bitw  = {quart_f, {FLD_W{1'b0}}, half_f, half_f};
        words.rate  = {{FLD_W{1'b0}}, div_f, rel_f};
        words.hold  = {{(WORD_W - FLD_W){1'b0}}, quart_f};
    end

endmodule

// File: rtl/i2c_tdiv_search.sv
module i2c_tdiv_search
    import i2ct_pkg::*;
#(
    parameter int RATIO_W = 32,
    parameter int FILT_W  = 3,
    parameter int STEPS   = 256,
    parameter int Q_MIN   = 5,
    parameter int Q_MAX   = 512,
    parameter int OFS     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [RATIO_W-1:0]         ratio,
    input  logic [FILT_W-1:0]          filt_cyc,
    output logic                       busy,
    output logic                       done,
    output logic                       err,
    output logic [$clog2(STEPS)-1:0]   clk_div,
    output logic [$clog2(Q_MAX)-1:0]   clk_cycle,
    output logic [31:0]                tw_edges,
    output logic [31:0]                tw_bit,
    output logic [31:0]                tw_rate,
    output logic [31:0]                tw_hold
);
    localparam int IDX_W = $clog2(STEPS);
    localparam int CYC_W = $clog2(Q_MAX);
    localparam int DVS_W = IDX_W + 1;
    localparam int EXT_W = RATIO_W + 1;

    srch_state_e state_q, state_d;

    logic [EXT_W-1:0]   base_ext;
    logic [RATIO_W-1:0] base_nxt;
    logic [RATIO_W-1:0] base_q;
    logic               accept;
    logic               scan_step;
    logic               div_load;
    logic [IDX_W-1:0]   scan_idx;
    logic               scan_hit;
    logic               scan_last;
    logic [DVS_W-1:0]   divisor;
    logic               div_ready;
    logic [CYC_W-1:0]   quo;
    logic [IDX_W-1:0]   clk_div_q;
    logic [CYC_W-1:0]   clk_cycle_q;
    timing_words_t      words_c;
    timing_words_t      words_q;

    // Base count, clamped to zero when the subtraction underflows.
    always_comb begin
        base_ext = EXT_W'(ratio) - EXT_W'(OFS) - (EXT_W'(filt_cyc) << 1);
        base_nxt = base_ext[EXT_W-1] ? '0 : base_ext[RATIO_W-1:0];
    end

    assign accept    = start && (state_q != ST_SCAN) && (state_q != ST_DIVIDE)
                       && (state_q != ST_PACK);
    assign scan_step = (state_q == ST_SCAN) && !scan_hit && !scan_last;
    assign div_load  = (state_q == ST_SCAN) && scan_hit;
    assign divisor   = DVS_W'(scan_idx) + DVS_W'(1);

    i2ct_scan #(
        .RATIO_W (RATIO_W),
        .STEPS   (STEPS),
        .Q_MIN   (Q_MIN),
        .Q_MAX   (Q_MAX)
    ) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (scan_step),
        .base  (base_q),
        .idx   (scan_idx),
        .hit   (scan_hit),
        .last  (scan_last)
    );

    i2ct_sdiv #(
        .DVD_W (RATIO_W),
        .DVS_W (DVS_W),
        .QO_W  (CYC_W)
    ) u_sdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (base_q),
        .divisor  (divisor),
        .ready    (div_ready),
        .quotient (quo)
    );

    i2ct_pack #(
        .IDX_W (IDX_W),
        .CYC_W (CYC_W)
    ) u_pack (
        .cyc   (clk_cycle_q),
        .div   (clk_div_q),
        .words (words_c)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SCAN;
            ST_SCAN: begin
                if (scan_hit)       state_d = ST_DIVIDE;
                else if (scan_last) state_d = ST_FAIL;
            end
            ST_DIVIDE: if (div_ready) state_d = ST_PACK;
            ST_PACK:   state_d = ST_DONE;
            ST_DONE:   if (accept) state_d = ST_SCAN;
            ST_FAIL:   if (accept) state_d = ST_SCAN;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            clk_div_q   <= '0;
            clk_cycle_q <= '0;
            words_q     <= '0;
        end else if (accept) begin
            base_q      <= base_nxt;
            clk_div_q   <= '0;
            clk_cycle_q <= '0;
            words_q     <= '0;
        end else begin
            if (div_load)
                clk_div_q <= scan_idx;
            if ((state_q == ST_DIVIDE) && div_ready)
                clk_cycle_q <= quo - CYC_W'(2);
            if (state_q == ST_PACK)
                words_q <= words_c;
        end
    end

    // Moore outputs.
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        err  = 1'b0;
        unique case (state_q)
            ST_SCAN, ST_DIVIDE, ST_PACK: busy = 1'b1;
            ST_DONE:                     done = 1'b1;
            ST_FAIL:                     err  = 1'b1;
            default: ;
        endcase
    end

    assign clk_div   = clk_div_q;
    assign clk_cycle = clk_cycle_q;
    assign tw_edges  = words_q.edges;
    assign tw_bit    = words_q.bitw;
    assign tw_rate   = words_q.rate;
    assign tw_hold   = words_q.hold;

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
    parameter int IDX_W   = 8,
    parameter int CYC_W   = 9,
    parameter int LAT_MAX = 292
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [IDX_W-1:0] clk_div,
    input logic [CYC_W-1:0] clk_cycle,
    input logic [31:0]      tw_edges,
    input logic [31:0]      tw_bit,
    input logic [31:0]      tw_rate,
    input logic [31:0]      tw_hold
);
    logic [15:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lat_q <= '0;
        else if (busy) lat_q <= lat_q + 16'd1;
        else           lat_q <= '0;
    end

    assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, err}));

    assert_start_begins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !err));

    assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(clk_div) && $stable(clk_cycle)
                              && $stable(tw_edges) && $stable(tw_bit)
                              && $stable(tw_rate) && $stable(tw_hold)));

    assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_fail_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (clk_div == '0 && clk_cycle == '0 && tw_edges == '0
                 && tw_bit == '0 && tw_rate == '0 && tw_hold == '0));

    assert_phase_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tw_edges[31:24] == tw_edges[23:16]
                  && tw_edges[23:16] == tw_edges[15:8]
                  && tw_edges[31:24] == tw_bit[15:8]
                  && tw_bit[15:8] == tw_bit[7:0]
                  && tw_edges[7:0] == 8'd0));

    assert_setup_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tw_hold[7:0] == tw_bit[31:24] && tw_hold[31:8] == 24'd0
                  && tw_bit[23:16] == 8'd0));

    assert_rate_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tw_rate[16 +: IDX_W] == clk_div
                  && tw_rate[15:0] == 16'(clk_cycle)
                  && tw_rate[31:24] == 8'd0));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lat_q < 16'(LAT_MAX)));

endmodule

bind i2c_tdiv_search i2ct_chk #(
    .IDX_W   (IDX_W),
    .CYC_W   (CYC_W),
    .LAT_MAX (STEPS + RATIO_W + 4)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .clk_div   (clk_div),
    .clk_cycle (clk_cycle),
    .tw_edges  (tw_edges),
    .tw_bit    (tw_bit),
    .tw_rate   (tw_rate),
    .tw_hold   (tw_hold)
);

// File: tb/tb_i2c_tdiv_search.sv
module tb_i2c_tdiv_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ratio = '0;
    logic [2:0]  filt_cyc = '0;
    logic        busy, done, err;
    logic [7:0]  clk_div;
    logic [8:0]  clk_cycle;
    logic [31:0] tw_edges, tw_bit, tw_rate, tw_hold;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // 250 MHz: 4 time-unit period
    always #2 clk = ~clk;

    i2c_tdiv_search dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ratio(ratio),
        .filt_cyc(filt_cyc), .busy(busy), .done(done), .err(err),
        .clk_div(clk_div), .clk_cycle(clk_cycle), .tw_edges(tw_edges),
        .tw_bit(tw_bit), .tw_rate(tw_rate), .tw_hold(tw_hold)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Reference model taken from the requirements.
    task automatic model(input logic [31:0] r, input logic [2:0] f,
                         output bit ok, output int dv, output int cy);
        longint b;
        b = longint'(r) - 8 - 2 * longint'(f);
        if (b < 0) b = 0;
        ok = 0; dv = 0; cy = 0;
        for (int i = 0; i < 256; i++) begin
            longint q;
            q = b / (i + 1);
            if (!ok && q > 4 && q < 512) begin
                ok = 1; dv = i; cy = int'(q) - 2;
            end
        end
    endtask

    task automatic wait_end(output int lat);
        lat = 0;
        while (!(done || err) && lat < 1000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // mode 0: plain; 1: disturb inputs after start (R8); 2: extra start while busy (R9)
    task automatic run_case(input logic [31:0] r, input logic [2:0] f, input int mode);
        bit ok; int dv, cy, lat, l, d;
        logic [31:0] e_edges, e_bit, e_rate, e_hold;
        model(r, f, ok, dv, cy);
        l = cy / 2; d = l / 2;
        e_edges = ok ? {l[7:0], l[7:0], l[7:0], 8'd0} : 32'd0;
        e_bit   = ok ? {d[7:0], 8'd0, l[7:0], l[7:0]} : 32'd0;
        e_rate  = ok ? {8'd0, dv[7:0], cy[15:0]} : 32'd0;
        e_hold  = ok ? {24'd0, d[7:0]} : 32'd0;

        @(negedge clk);
        ratio = r; filt_cyc = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !err, "R8", "busy after start", {29'd0, busy, done, err}, 32'd4);
        if (mode == 1) begin
            ratio = $urandom; filt_cyc = 3'($urandom);
        end
        if (mode == 2) begin
            repeat (3) @(negedge clk);
            ratio = 32'd600; filt_cyc = 3'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy, "R9", "start while busy ignored", {31'd0, busy}, 32'd1);
        end
        wait_end(lat);
        chk(lat <= 256 + 32 + 4, "R10", "latency", lat, 292);
        chk(done == ok && err == !ok, ok ? "R3" : "R4", "done/err",
            {30'd0, done, err}, {30'd0, ok, !ok});
        chk(clk_div == dv[7:0], ok ? "R3" : "R4", "clk_div", clk_div, dv);
        chk(clk_cycle == cy[8:0], ok ? "R3" : "R4", "clk_cycle", clk_cycle, cy);
        chk(tw_edges == e_edges, "R5", "tw_edges", tw_edges, e_edges);
        chk(tw_bit == e_bit, "R6", "tw_bit", tw_bit, e_bit);
        chk(tw_rate == e_rate, "R7", "tw_rate", tw_rate, e_rate);
        chk(tw_hold == e_hold, "R6", "tw_hold", tw_hold, e_hold);
        if (mode != 0) begin
            repeat (5) @(negedge clk);
            chk(done == ok && err == !ok && tw_rate == e_rate, "R11", "held result",
                tw_rate, e_rate);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5eed));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err, "R1", "flags at reset", {29'd0, busy, done, err}, 0);
        chk(clk_div == 0 && clk_cycle == 0, "R1", "result at reset",
            {23'd0, clk_cycle}, 0);
        chk((tw_edges | tw_bit | tw_rate | tw_hold) == 0, "R1", "words at reset",
            tw_edges | tw_bit | tw_rate | tw_hold, 0);
        rst_n = 1'b1;

        // Directed corners
        run_case(32'd7, 3'd0, 0);          // R2 underflow -> error
        run_case(32'd21, 3'd7, 0);         // R2 underflow with filter
        run_case(32'd27, 3'd7, 0);         // R2 base 5 -> div 0, cycle 3
        run_case(32'd27, 3'd0, 0);         // R2 base 19
        run_case(32'd12, 3'd0, 0);         // R4 base 4 fails
        run_case(32'd519, 3'd0, 0);        // R3 base 511
        run_case(32'd520, 3'd0, 1);        // R3 base 512 -> div 1
        run_case(32'd131079, 3'd0, 0);     // R3 base 131071 -> div 255
        run_case(32'd131080, 3'd0, 2);     // R4 base 131072 fails
        run_case(32'hFFFF_FFFF, 3'd3, 0);  // R4 huge ratio

        // Constrained random
        for (int n = 0; n < 40; n++) begin
            logic [31:0] r;
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0)      r = $urandom_range(0, 2000);
            else if (sel == 3) r = $urandom;
            else               r = $urandom_range(2000, 140000);
            run_case(r, 3'($urandom), n % 3);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule